// File: doc/BRIEF.md
# Parallel NOR Flash Byte-Program Sequencer

This block sits on the host side of an asynchronous x8 parallel NOR flash device and writes one byte at a time. A request carries a 16-bit byte address and an 8-bit value. The block first holds off all flash activity for a power-up lockout window. It then drives three command write cycles and the target write onto the flash pins. After that it reads the device repeatedly until the internal program operation reports completion.

The block reports completion in one of two ways. A `done_o` pulse means the program finished. A `timeout_o` pulse means no completion was seen within the allowed time. Completion is detected by one of two status methods, chosen per request by `poll_toggle_i`.

The host writes a request through a valid/ready handshake. The block accepts one request at a time. The strobe widths and the read access time are parameters counted in clock cycles.

Top module: `nor_prog_seq`

## Requirements
- R1: For the first PWRUP_CYCLES clock cycles after reset release, `req_ready_o` stays low and `fl_ce_no` stays high, even when `req_valid_i` is held high. `req_ready_o` rises no later than two cycles after that window ends.
- R2: A request is accepted on a clock edge where `req_valid_i` and `req_ready_o` are both high. From the cycle after acceptance, `req_ready_o` stays low until the cycle carrying `done_o` or `timeout_o`.
- R3: Each request produces exactly four flash write cycles, in this order: address 16'h5555 with data 8'hAA, then 16'h2AAA with 8'h55, then 16'h5555 with 8'hA0, then the request address with the request data.
- R4: Every write cycle holds `fl_ce_no` low and `fl_oe_no` high while `fl_we_no` is low. Address and data are unchanged across the rising edge of `fl_we_no` and for at least one cycle after it.
- R5: Every status read holds `fl_ce_no` low and `fl_we_no` high while `fl_oe_no` is low. The host does not drive `fl_dq_io` during a read, and it samples the bus after T_ACCESS cycles of `fl_oe_no` low.
- R6: With `poll_toggle_i`=0 at acceptance, the operation completes on the first status read whose bit 7 equals bit 7 of the request data.
- R7: With `poll_toggle_i`=1 at acceptance, the operation completes on the first status read whose bit 6 equals bit 6 of the read just before it. The first read after the target write can never complete the operation.
- R8: Suppose TIMEOUT_CYCLES cycles have passed since polling began and a status read still shows no completion. Then the block ends the operation with `timeout_o`, within one more read cycle.
- R9: `done_o` and `timeout_o` are each one cycle wide and never high together. `req_ready_o` is high in the same cycle as either pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request valid |
| req_ready_o | output | 1 | Block idle and able to take a request |
| req_addr_i | input | 16 | Target byte address |
| req_data_i | input | 8 | Byte to program |
| poll_toggle_i | input | 1 | Completion method: 0 = bit-7 data compare, 1 = bit-6 toggle compare |
| done_o | output | 1 | One-cycle pulse, program complete |
| timeout_o | output | 1 | One-cycle pulse, completion not seen in time |
| fl_addr_o | output | 16 | Flash address bus |
| fl_dq_io | inout | 8 | Flash data bus |
| fl_ce_no | output | 1 | Flash chip enable, active low |
| fl_oe_no | output | 1 | Flash output enable, active low |
| fl_we_no | output | 1 | Flash write enable, active low |

## Verification
Suppose the command step counter is wrong. The four write cycles captured at each `fl_we_no` rising edge then show a wrong address or data, or a wrong count, before the first status read. This is visible within a few dozen cycles of acceptance.

Suppose the completion compare or the stored previous toggle bit is wrong. The number of status reads before `done_o` then differs from the count expected for the device model's busy length, or a timeout appears where completion was due.

Suppose a lockout or timeout counter is off. `req_ready_o` then rises at the wrong cycle, or `timeout_o` falls outside its window. These errors take thousands of cycles to show.

// File: rtl/nor_prog_pkg.sv
package nor_prog_pkg;

  localparam int unsigned ADDR_W   = 16;
  localparam int unsigned DATA_W   = 8;
  localparam int unsigned STS_BIT  = 7;   // data compare status bit
  localparam int unsigned TGL_BIT  = 6;   // toggling status bit
  localparam logic [1:0]  LAST_STEP = 2'd3;

  typedef enum logic [2:0] {
    S_LOCK, S_IDLE, S_CMD, S_WAIT_W, S_POLL, S_WAIT_R
  } seq_state_e;

  typedef enum logic [2:0] {
    B_IDLE, B_SETUP, B_PULSE, B_HOLD, B_READ
  } bus_state_e;

  function automatic logic [ADDR_W-1:0] unlock_addr(input logic [1:0] step);
    case (step)
      2'd1:    unlock_addr = 16'h2AAA;
      default: unlock_addr = 16'h5555;
    endcase
  endfunction

  function automatic logic [DATA_W-1:0] unlock_data(input logic [1:0] step);
    case (step)
      2'd0:    unlock_data = 8'hAA;
      2'd1:    unlock_data = 8'h55;
      default: unlock_data = 8'hA0;
    endcase
  endfunction

endpackage

// File: rtl/nor_lockout.sv
module nor_lockout #(
  parameter int unsigned CYCLES = 25000
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic ok_o
);
  localparam int unsigned CW = $clog2(CYCLES + 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      ok_o  <= 1'b0;
    end else if (!ok_o) begin
      cnt_q <= cnt_q + 1'b1;
      ok_o  <= (cnt_q == CW'(CYCLES - 1));
    end
  end
endmodule

// File: rtl/nor_bus_cycle.sv
module nor_bus_cycle
  import nor_prog_pkg::*;
#(
  parameter int unsigned T_SETUP  = 1,
  parameter int unsigned T_PULSE  = 2,
  parameter int unsigned T_HOLD   = 1,
  parameter int unsigned T_ACCESS = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              read_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              busy_o,
  output logic              done_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic [ADDR_W-1:0] fl_addr_o,
  output logic [DATA_W-1:0] fl_dout_o,
  output logic              fl_dq_oe_o,
  input  logic [DATA_W-1:0] fl_din_i,
  output logic              fl_ce_no,
  output logic              fl_oe_no,
  output logic              fl_we_no
);
  localparam int unsigned T_A  = (T_SETUP > T_PULSE) ? T_SETUP : T_PULSE;
  localparam int unsigned T_B  = (T_HOLD > T_ACCESS) ? T_HOLD : T_ACCESS;
  localparam int unsigned TMAX = (T_A > T_B) ? T_A : T_B;
  localparam int unsigned CW   = $clog2(TMAX + 1);

  bus_state_e        state_q;
  logic [CW-1:0]     cnt_q, lim;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] data_q;
  logic              last;

  always_comb begin
    case (state_q)
      B_SETUP: lim = CW'(T_SETUP - 1);
      B_PULSE: lim = CW'(T_PULSE - 1);
      B_HOLD:  lim = CW'(T_HOLD - 1);
      default: lim = CW'(T_ACCESS - 1);
    endcase
  end
  assign last = (cnt_q == lim);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= B_IDLE;
      cnt_q   <= '0;
      addr_q  <= '0;
      data_q  <= '0;
      rdata_o <= '0;
      done_o  <= 1'b0;
    end else begin
      done_o <= 1'b0;
      case (state_q)
        B_IDLE: if (start_i) begin
          addr_q  <= addr_i;
          data_q  <= data_i;
          cnt_q   <= '0;
          state_q <= read_i ? B_READ : B_SETUP;
        end
        B_SETUP: if (last) begin state_q <= B_PULSE; cnt_q <= '0; end
                 else cnt_q <= cnt_q + 1'b1;
        B_PULSE: if (last) begin state_q <= B_HOLD; cnt_q <= '0; end
                 else cnt_q <= cnt_q + 1'b1;
        B_HOLD:  if (last) begin state_q <= B_IDLE; done_o <= 1'b1; end
                 else cnt_q <= cnt_q + 1'b1;
        B_READ:  if (last) begin
                   state_q <= B_IDLE;
                   done_o  <= 1'b1;
                   rdata_o <= fl_din_i;
                 end else cnt_q <= cnt_q + 1'b1;
        default: state_q <= B_IDLE;
      endcase
    end
  end

  assign busy_o     = (state_q != B_IDLE);
  assign fl_addr_o  = addr_q;
  assign fl_dout_o  = data_q;
  assign fl_dq_oe_o = (state_q == B_SETUP) || (state_q == B_PULSE) || (state_q == B_HOLD);
  assign fl_ce_no   = (state_q == B_IDLE);
  assign fl_we_no   = (state_q != B_PULSE);
  assign fl_oe_no   = (state_q != B_READ);
endmodule

// File: rtl/nor_poll_check.sv
module nor_poll_check (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clear_i,
  input  logic sample_i,
  input  logic rd_sts_i,
  input  logic rd_tgl_i,
  input  logic want_sts_i,
  input  logic toggle_mode_i,
  output logic complete_o
);
  logic have_prev_q, prev_tgl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      have_prev_q <= 1'b0;
      prev_tgl_q  <= 1'b0;
    end else if (clear_i) begin
      have_prev_q <= 1'b0;
    end else if (sample_i) begin
      have_prev_q <= 1'b1;
      prev_tgl_q  <= rd_tgl_i;
    end
  end

  assign complete_o = sample_i &&
    (toggle_mode_i ? (have_prev_q && (prev_tgl_q == rd_tgl_i))
                   : (rd_sts_i == want_sts_i));
endmodule

// File: rtl/nor_prog_seq.sv
module nor_prog_seq
  import nor_prog_pkg::*;
#(
  parameter int unsigned PWRUP_CYCLES   = 25000,
  parameter int unsigned TIMEOUT_CYCLES = 9000,
  parameter int unsigned T_SETUP        = 1,
  parameter int unsigned T_PULSE        = 2,
  parameter int unsigned T_HOLD         = 1,
  parameter int unsigned T_ACCESS       = 3
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        req_valid_i,
  output logic        req_ready_o,
  input  logic [15:0] req_addr_i,
  input  logic [7:0]  req_data_i,
  input  logic        poll_toggle_i,
  output logic        done_o,
  output logic        timeout_o,
  output logic [15:0] fl_addr_o,
  inout  wire  [7:0]  fl_dq_io,
  output logic        fl_ce_no,
  output logic        fl_oe_no,
  output logic        fl_we_no
);
  localparam int unsigned TW = $clog2(TIMEOUT_CYCLES + 1);

  seq_state_e        state_q;
  logic [1:0]        step_q;
  logic [ADDR_W-1:0] addr_q, bus_addr;
  logic [DATA_W-1:0] data_q, bus_data, bus_rdata, dout;
  logic              mode_q;
  logic [TW-1:0]     tcnt_q;
  logic              lock_ok, bus_start, bus_busy, bus_done, dq_oe;
  logic              poll_clear, poll_sample, complete, in_poll;

  nor_lockout #(.CYCLES(PWRUP_CYCLES)) u_lock (
    .clk_i(clk_i), .rst_ni(rst_ni), .ok_o(lock_ok)
  );

  assign bus_start = ((state_q == S_CMD) || (state_q == S_POLL)) && !bus_busy;
  assign bus_addr  = ((state_q == S_POLL) || (step_q == LAST_STEP)) ? addr_q
                                                                   : unlock_addr(step_q);
  assign bus_data  = (step_q == LAST_STEP) ? data_q : unlock_data(step_q);

  nor_bus_cycle #(
    .T_SETUP(T_SETUP), .T_PULSE(T_PULSE), .T_HOLD(T_HOLD), .T_ACCESS(T_ACCESS)
  ) u_bus (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .start_i(bus_start), .read_i(state_q == S_POLL),
    .addr_i(bus_addr), .data_i(bus_data),
    .busy_o(bus_busy), .done_o(bus_done), .rdata_o(bus_rdata),
    .fl_addr_o(fl_addr_o), .fl_dout_o(dout), .fl_dq_oe_o(dq_oe),
    .fl_din_i(fl_dq_io),
    .fl_ce_no(fl_ce_no), .fl_oe_no(fl_oe_no), .fl_we_no(fl_we_no)
  );

  assign fl_dq_io = dq_oe ? dout : 8'hzz;

  assign poll_clear  = (state_q == S_WAIT_W) && bus_done && (step_q == LAST_STEP);
  assign poll_sample = (state_q == S_WAIT_R) && bus_done;

  nor_poll_check u_poll (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .clear_i(poll_clear), .sample_i(poll_sample),
    .rd_sts_i(bus_rdata[STS_BIT]), .rd_tgl_i(bus_rdata[TGL_BIT]),
    .want_sts_i(data_q[STS_BIT]), .toggle_mode_i(mode_q),
    .complete_o(complete)
  );

  assign in_poll = (state_q == S_POLL) || (state_q == S_WAIT_R);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) tcnt_q <= '0;
    else if (poll_clear) tcnt_q <= '0;
    else if (in_poll && (tcnt_q != TW'(TIMEOUT_CYCLES))) tcnt_q <= tcnt_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= S_LOCK;
      step_q    <= '0;
      addr_q    <= '0;
      data_q    <= '0;
      mode_q    <= 1'b0;
      done_o    <= 1'b0;
      timeout_o <= 1'b0;
    end else begin
      done_o    <= 1'b0;
      timeout_o <= 1'b0;
      case (state_q)
        S_LOCK: if (lock_ok) state_q <= S_IDLE;
        S_IDLE: if (req_valid_i) begin
          addr_q  <= req_addr_i;
          data_q  <= req_data_i;
          mode_q  <= poll_toggle_i;
          step_q  <= '0;
          state_q <= S_CMD;
        end
        S_CMD:  if (bus_start) state_q <= S_WAIT_W;
        S_WAIT_W: if (bus_done) begin
          if (step_q == LAST_STEP) state_q <= S_POLL;
          else begin
            step_q  <= step_q + 1'b1;
            state_q <= S_CMD;
          end
        end
        S_POLL: if (bus_start) state_q <= S_WAIT_R;
        S_WAIT_R: if (bus_done) begin
          if (complete) begin
            done_o  <= 1'b1;
            state_q <= S_IDLE;
          end else if (tcnt_q >= TW'(TIMEOUT_CYCLES)) begin
            timeout_o <= 1'b1;
            state_q   <= S_IDLE;
          end else state_q <= S_POLL;
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  assign req_ready_o = (state_q == S_IDLE);
endmodule

// File: rtl/nor_prog_seq_chk.sv
module nor_prog_seq_chk #(
  parameter int unsigned PWRUP_CYCLES = 25000
) (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        req_ready_o,
  input logic        done_o,
  input logic        timeout_o,
  input logic [15:0] fl_addr_o,
  input logic [7:0]  fl_dq_io,
  input logic        fl_ce_no,
  input logic        fl_oe_no,
  input logic        fl_we_no
);
  localparam int unsigned CW = $clog2(PWRUP_CYCLES + 1);
  logic [CW-1:0] lk_cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) lk_cnt <= '0;
    else if (lk_cnt != CW'(PWRUP_CYCLES)) lk_cnt <= lk_cnt + 1'b1;
  end

  p_lockout_quiet_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lk_cnt < CW'(PWRUP_CYCLES)) |-> (fl_ce_no && !req_ready_o));

  p_busy_not_ready_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fl_ce_no |-> !req_ready_o);

  p_write_strobe_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fl_we_no |-> (!fl_ce_no && fl_oe_no));

  p_we_rise_stable_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(fl_we_no) |-> ($stable(fl_addr_o) && $stable(fl_dq_io)));

  p_we_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(fl_we_no) |=> $stable(fl_addr_o));

  p_read_strobe_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fl_oe_no |-> (!fl_ce_no && fl_we_no));

  p_end_exclusive_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(done_o && timeout_o));

  p_end_ready_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o || timeout_o) |-> req_ready_o);

  p_done_pulse_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  p_timeout_pulse_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    timeout_o |=> !timeout_o);
endmodule

bind nor_prog_seq nor_prog_seq_chk #(.PWRUP_CYCLES(PWRUP_CYCLES)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .req_ready_o(req_ready_o),
  .done_o(done_o), .timeout_o(timeout_o), .fl_addr_o(fl_addr_o),
  .fl_dq_io(fl_dq_io), .fl_ce_no(fl_ce_no), .fl_oe_no(fl_oe_no),
  .fl_we_no(fl_we_no)
);

// File: tb/sim_nor_prog_seq.sv
module sim_nor_prog_seq;
  localparam int PWRUP   = 25000;
  localparam int TIMEOUT = 9000;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_ready, poll_toggle = 1'b0, done, tmo;
  logic [15:0] req_addr = '0, fl_addr;
  logic [7:0]  req_data = '0;
  wire  [7:0]  fl_dq;
  logic fl_ce_n, fl_oe_n, fl_we_n;

  int checks = 0, errors = 0, cyc = 0;
  int wr_n = 0, rd_idx = 0, busy_reads = 0, t_wr = 0, we_viol = 0, rd_viol = 0;
  logic [15:0] wr_addr [4];
  logic [7:0]  wr_data [4];
  logic [7:0]  pd = '0, mval;

  always #2 clk = ~clk;
  always @(posedge clk) cyc++;

  nor_prog_seq #(.PWRUP_CYCLES(PWRUP), .TIMEOUT_CYCLES(TIMEOUT)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .req_ready_o(req_ready),
    .req_addr_i(req_addr), .req_data_i(req_data), .poll_toggle_i(poll_toggle),
    .done_o(done), .timeout_o(tmo), .fl_addr_o(fl_addr), .fl_dq_io(fl_dq),
    .fl_ce_no(fl_ce_n), .fl_oe_no(fl_oe_n), .fl_we_no(fl_we_n)
  );

  // device model: busy reads flip bit 6 and invert bit 7, then return the byte
  always_comb begin
    if (rd_idx < busy_reads) mval = {~pd[7], rd_idx[0], pd[5:0]};
    else mval = pd;
  end
  assign fl_dq = (!fl_ce_n && !fl_oe_n) ? mval : 8'hzz;

  always @(posedge fl_we_n) if (rst_n) begin
    if (wr_n < 4) begin wr_addr[wr_n] = fl_addr; wr_data[wr_n] = fl_dq; end
    if (fl_ce_n || !fl_oe_n) we_viol++;
    if (wr_n == 3) begin pd = fl_dq; rd_idx = 0; t_wr = cyc; end
    wr_n++;
  end
  always @(negedge fl_we_n) if (rst_n && (fl_ce_n || !fl_oe_n)) we_viol++;
  always @(negedge fl_oe_n) if (rst_n && (fl_ce_n || !fl_we_n)) rd_viol++;
  always @(posedge fl_oe_n) if (rst_n) rd_idx++;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic bit b6(input int i, input int busy, input logic [7:0] d);
    if (i < busy) return i[0];
    return d[6];
  endfunction

  function automatic int exp_reads(input bit mode, input int busy, input logic [7:0] d);
    if (!mode) return busy + 1;
    for (int r = 1; r < busy + 3; r++)
      if (b6(r, busy, d) == b6(r - 1, busy, d)) return r + 1;
    return -1;
  endfunction

  task automatic do_req(input logic [15:0] a, input logic [7:0] d, input bit mode,
                        input int busy, input bit want_to);
    int wait_n;
    busy_reads = busy;
    wr_n = 0;
    rd_idx = 0;
    @(negedge clk);
    req_addr = a; req_data = d; poll_toggle = mode; req_valid = 1'b1;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    chk(!req_ready, "R2 ready low after accept", req_ready, 0);
    poll_toggle = ~mode;  // later changes must not matter
    wait_n = 0;
    while (!(done || tmo) && wait_n < 20000) begin
      @(negedge clk);
      wait_n++;
    end
    chk(req_ready, "R9 ready with end pulse", req_ready, 1);
    chk(wr_n == 4, "R3 write count", wr_n, 4);
    chk(wr_addr[0] == 16'h5555 && wr_data[0] == 8'hAA, "R3 cycle0", {wr_addr[0], wr_data[0]}, 24'h5555AA);
    chk(wr_addr[1] == 16'h2AAA && wr_data[1] == 8'h55, "R3 cycle1", {wr_addr[1], wr_data[1]}, 24'h2AAA55);
    chk(wr_addr[2] == 16'h5555 && wr_data[2] == 8'hA0, "R3 cycle2", {wr_addr[2], wr_data[2]}, 24'h5555A0);
    chk(wr_addr[3] == a && wr_data[3] == d, "R3 target", {wr_addr[3], wr_data[3]}, {a, d});
    chk(we_viol == 0, "R4 write strobes", we_viol, 0);
    chk(rd_viol == 0 && rd_idx > 0, "R5 read strobes", rd_viol, 0);
    if (want_to) begin
      chk(tmo && !done, "R8 timeout flagged", {done, tmo}, 2'b01);
      chk((cyc - t_wr) >= TIMEOUT && (cyc - t_wr) <= TIMEOUT + 20, "R8 timeout window",
          cyc - t_wr, TIMEOUT);
    end else begin
      chk(done && !tmo, mode ? "R7 done" : "R6 done", {done, tmo}, 2'b10);
      chk(rd_idx == exp_reads(mode, busy, d), mode ? "R7 read count" : "R6 read count",
          rd_idx, exp_reads(mode, busy, d));
    end
    @(negedge clk);
    chk(!done && !tmo, "R9 single-cycle pulse", {done, tmo}, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int n;
    bit ce_seen;
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    chk(!req_ready && !done && !tmo && fl_ce_n && fl_we_n && fl_oe_n, "R1 reset state",
        {req_ready, done, tmo, fl_ce_n, fl_we_n, fl_oe_n}, 6'b000111);
    req_valid = 1'b1;
    rst_n = 1'b1;
    n = 0;
    ce_seen = 1'b0;
    while (!req_ready && n < PWRUP + 10) begin
      @(negedge clk);
      n++;
      if (!fl_ce_n) ce_seen = 1'b1;
    end
    req_valid = 1'b0;
    chk(!ce_seen, "R1 bus idle during lockout", ce_seen, 0);
    chk(n >= PWRUP && n <= PWRUP + 2, "R1 lockout length", n, PWRUP);

    // directed corners
    do_req(16'h0000, 8'h80, 1'b0, 0, 1'b0);
    do_req(16'hFFFF, 8'h00, 1'b0, 5, 1'b0);
    do_req(16'h1234, 8'h40, 1'b1, 0, 1'b0);
    do_req(16'h5555, 8'h00, 1'b1, 3, 1'b0);
    do_req(16'h2AAA, 8'h40, 1'b1, 4, 1'b0);
    for (int i = 0; i < 12; i++)
      do_req(16'($urandom), 8'($urandom), 1'($urandom), int'($urandom_range(0, 7)), 1'b0);
    do_req(16'hBEEF, 8'h7F, 1'b0, 1000000, 1'b1);
    do_req(16'hCAFE, 8'hC3, 1'b1, 1000000, 1'b1);
    do_req(16'h0101, 8'h5A, 1'b0, 2, 1'b0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule